// File: doc/BRIEF.md
# Fractional Sample-Rate Converter with Cubic Interpolation

This block converts a stream of 16-bit signed samples to another sample rate. A static rate ratio, equal to the input rate divided by the output rate, sets the output rate. A modulus phase accumulator tracks where each output instant falls on the input timeline. The whole-sample part of each phase step sets how many new input samples must enter a four-sample window. The fractional part `mu` is the interpolation point between the two centre samples of that window.

Each output comes from a cubic Lagrange polynomial fitted to the four window samples. The polynomial is held in a variable-delay form: three coefficient sums are computed once per window, and the value at `mu` is then found by three Horner multiply-add steps. The result is divided by six, added to the centre sample and clipped to the 16-bit range.

Input uses a valid/ready handshake. Output is a valid-qualified stream with no backpressure. The ratio is expected to be supplied by a surrounding rate-tracking loop, or held constant.

Top module: `farrow_resampler`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The first four accepted samples only fill the window. No output appears until the fourth sample has been accepted.
- R3: Output k (counting from 0 after reset) is the interpolated value at input index 1 + k·ratio/65536, where input index 0 is the first accepted sample. The integer part of that index selects x[n] and the fraction is `mu`.
- R4: `ratio` is unsigned with 4 integer bits [19:16] and 16 fraction bits [15:0]. Each whole unit produced by the phase step requires one new input sample. A ratio with a nonzero integer part always requests input after each output.
- R5: `in_ready` is low exactly while the current window still serves the next output. Every accepted sample enters the window in order, and none is lost or repeated, whatever gaps appear in `in_valid`.
- R6: Each output is the cubic Lagrange interpolation through x[n−1], x[n], x[n+1], x[n+2] at `mu`. It is within 1 LSB of the exact value rounded to nearest.
- R7: When `mu` is 0, the output equals x[n] exactly. With ratio 1.0 (0x10000), the output stream is an exact copy of the input stream, starting at the second sample.
- R8: Results beyond the 16-bit range saturate to 32767 or −32768.
- R9: A constant input stream is reproduced exactly at any ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio | input | 20 | Input/output rate ratio, unsigned, 4.16 fixed point |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample this cycle |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | Output sample present |
| out_data | output | 16 | Output sample, signed, saturated |

## Verification
An output can leave the Horner pipeline in the same cycle that a new input sample shifts into the window. This happens because the pipeline is still finishing earlier phases while the handshake refills the window. The bench provokes this overlap with input gaps of varying length at ratio 1.5, and with back-to-back input at ratios below and above one. In each case the full output sequence is compared, sample by sample, against a real-valued Lagrange model indexed by k·ratio. The output count is compared against the number of phases the supplied samples can cover. A slip in the window or in the phase would therefore show up as a mismatch in value or count.

// File: rtl/frs_pkg.sv
package frs_pkg;
  // sample width, phase fraction bits, ratio integer bits
  parameter int DW   = 16;
  parameter int FW   = 16;
  parameter int RIW  = 4;
  parameter int TAPS = 4;
  // derived widths
  parameter int RW   = RIW + FW;      // ratio word
  parameter int NW   = RIW + 1;       // pending-sample counter
  parameter int CW   = DW + 6;        // coefficient / Horner accumulator
  parameter int KSH  = 24;            // shift of the divide-by-six constant
  parameter int KW   = KSH + 1;
endpackage

// File: rtl/frs_phase_ctrl.sv
module frs_phase_ctrl
  import frs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [RW-1:0]           ratio,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [DW-1:0]    in_data,
  output logic                    fire,
  output logic [TAPS-1:0][DW-1:0] win,
  output logic [FW-1:0]           mu
);
  logic [NW-1:0] need;
  logic [NW+FW-1:0] step_sum;
  logic accept;

  assign in_ready = (need != '0);
  assign fire     = (need == '0);
  assign accept   = in_valid && in_ready;
  assign step_sum = {1'b0, ratio} + {{NW{1'b0}}, mu};

  always_ff @(posedge clk) begin
    if (rst) begin
      need <= NW'(TAPS);
      mu   <= '0;
      win  <= '0;
    end else if (fire) begin
      need <= step_sum[FW +: NW];
      mu   <= step_sum[FW-1:0];
    end else if (accept) begin
      win  <= {in_data, win[TAPS-1:1]};
      need <= need - 1'b1;
    end
  end

  // R5
  ready_held_chk: assert property (@(posedge clk) disable iff (rst)
    (in_ready && !in_valid) |=> in_ready);
  // R5
  sample_kept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (win[TAPS-1] == $past(in_data)));
  // R4
  whole_step_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && (ratio[RW-1:FW] != '0)) |=> in_ready);
endmodule

// File: rtl/frs_coef.sv
module frs_coef
  import frs_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    fire,
  input  logic [TAPS-1:0][DW-1:0] win,
  input  logic [FW-1:0]           mu,
  output logic                    o_vld,
  output logic [FW-1:0]           o_mu,
  output logic signed [DW-1:0]    o_x0,
  output logic signed [CW-1:0]    o_c3,
  output logic signed [CW-1:0]    o_c2,
  output logic signed [CW-1:0]    o_c1
);
  logic signed [CW-1:0] em, e0, e1, e2;
  logic signed [CW-1:0] k1, k2, k3;

  // sign-extend the four window taps
  assign em = CW'($signed(win[0]));
  assign e0 = CW'($signed(win[1]));
  assign e1 = CW'($signed(win[2]));
  assign e2 = CW'($signed(win[3]));

  // Lagrange cubic coefficients scaled by six
  assign k1 = -(em <<< 1) - (e0 <<< 1) - e0 + (e1 <<< 2) + (e1 <<< 1) - e2;
  assign k2 = (em <<< 1) + em - (e0 <<< 2) - (e0 <<< 1) + (e1 <<< 1) + e1;
  assign k3 = -em + (e0 <<< 1) + e0 - (e1 <<< 1) - e1 + e2;

  always_ff @(posedge clk) begin
    if (rst) o_vld <= 1'b0;
    else     o_vld <= fire;
    o_mu <= mu;
    o_x0 <= $signed(win[1]);
    o_c3 <= k3;
    o_c2 <= k2;
    o_c1 <= k1;
  end
endmodule

// File: rtl/frs_horner_step.sv
module frs_horner_step
  import frs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_vld,
  input  logic [FW-1:0]        i_mu,
  input  logic signed [DW-1:0] i_x0,
  input  logic signed [CW-1:0] i_acc,
  input  logic signed [CW-1:0] i_add,
  output logic                 o_vld,
  output logic [FW-1:0]        o_mu,
  output logic signed [DW-1:0] o_x0,
  output logic signed [CW-1:0] o_acc
);
  localparam int PW = CW + FW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FW - 1);

  logic signed [PW-1:0] a_ext, m_ext, prod, shifted;

  assign a_ext   = PW'(i_acc);
  assign m_ext   = PW'($signed({1'b0, i_mu}));
  assign prod    = a_ext * m_ext;
  assign shifted = (prod + HALF) >>> FW;

  always_ff @(posedge clk) begin
    if (rst) o_vld <= 1'b0;
    else     o_vld <= i_vld;
    o_mu  <= i_mu;
    o_x0  <= i_x0;
    o_acc <= $signed(shifted[CW-1:0]) + i_add;
  end

  // R3
  step_flow_chk: assert property (@(posedge clk) disable iff (rst)
    i_vld |=> o_vld);
endmodule

// File: rtl/frs_scale_sat.sv
module frs_scale_sat
  import frs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 i_vld,
  input  logic [FW-1:0]        i_mu,
  input  logic signed [DW-1:0] i_x0,
  input  logic signed [CW-1:0] i_h,
  output logic                 o_vld,
  output logic signed [DW-1:0] o_y
);
  localparam int PW = CW + KW;
  // round(2^KSH / 6)
  localparam logic signed [PW-1:0] KDIV = PW'(((64'd1 << KSH) + 64'd3) / 64'd6);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (KSH - 1);
  localparam logic signed [CW-1:0] YMAX = CW'((64'd1 << (DW - 1)) - 64'd1);
  localparam logic signed [CW-1:0] YMIN = -YMAX - CW'(1);

  logic signed [PW-1:0] prod, shifted;
  logic signed [CW-1:0] sum;

  assign prod    = PW'(i_h) * KDIV;
  assign shifted = (prod + HALF) >>> KSH;
  assign sum     = CW'(i_x0) + $signed(shifted[CW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) o_vld <= 1'b0;
    else     o_vld <= i_vld;
    if (sum > YMAX)      o_y <= YMAX[DW-1:0];
    else if (sum < YMIN) o_y <= YMIN[DW-1:0];
    else                 o_y <= sum[DW-1:0];
  end

  // R7
  on_grid_chk: assert property (@(posedge clk) disable iff (rst)
    (i_vld && (i_mu == '0)) |=> (o_vld && (o_y == $past(i_x0))));
  // R8
  clip_chk: assert property (@(posedge clk) disable iff (rst)
    (i_vld && (sum > YMAX)) |=> (o_y == YMAX[DW-1:0]));
endmodule

// File: rtl/farrow_resampler.sv
module farrow_resampler
  import frs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RW-1:0]        ratio,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int NSTEP = 3;

  logic                    fire;
  logic [TAPS-1:0][DW-1:0] win;
  logic [FW-1:0]           mu;

  logic                 st_vld [NSTEP+1];
  logic [FW-1:0]        st_mu  [NSTEP+1];
  logic signed [DW-1:0] st_x0  [NSTEP+1];
  logic signed [CW-1:0] st_acc [NSTEP+1];
  logic signed [CW-1:0] st_add [NSTEP];
  logic signed [CW-1:0] c2, c1, c1_d;

  frs_phase_ctrl u_phase (
    .clk(clk), .rst(rst), .ratio(ratio),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .fire(fire), .win(win), .mu(mu)
  );

  frs_coef u_coef (
    .clk(clk), .rst(rst), .fire(fire), .win(win), .mu(mu),
    .o_vld(st_vld[0]), .o_mu(st_mu[0]), .o_x0(st_x0[0]),
    .o_c3(st_acc[0]), .o_c2(c2), .o_c1(c1)
  );

  // c1 joins one stage after c2
  always_ff @(posedge clk) c1_d <= c1;

  generate
    for (genvar s = 0; s < NSTEP; s++) begin : g_step
      if (s == 0) begin : g_a2
        assign st_add[s] = c2;
      end else if (s == 1) begin : g_a1
        assign st_add[s] = c1_d;
      end else begin : g_a0
        assign st_add[s] = '0;
      end
      frs_horner_step u_step (
        .clk(clk), .rst(rst),
        .i_vld(st_vld[s]), .i_mu(st_mu[s]), .i_x0(st_x0[s]),
        .i_acc(st_acc[s]), .i_add(st_add[s]),
        .o_vld(st_vld[s+1]), .o_mu(st_mu[s+1]), .o_x0(st_x0[s+1]),
        .o_acc(st_acc[s+1])
      );
    end
  endgenerate

  frs_scale_sat u_sat (
    .clk(clk), .rst(rst),
    .i_vld(st_vld[NSTEP]), .i_mu(st_mu[NSTEP]), .i_x0(st_x0[NSTEP]),
    .i_h(st_acc[NSTEP]),
    .o_vld(out_valid), .o_y(out_data)
  );
endmodule

// File: tb/test_farrow_resampler.sv
module test_farrow_resampler;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [19:0] ratio = 20'h10000;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic signed [15:0] in_data = '0;
  logic        out_valid;
  logic signed [15:0] out_data;

  int total = 0;
  int bad   = 0;
  int n_out = 0;
  int outs [1024];
  int stim [128];

  always #4 clk = ~clk;  // 125 MHz

  farrow_resampler i_farrow_resampler (
    .clk(clk), .rst(rst), .ratio(ratio),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  always @(negedge clk)
    if (!rst && out_valid && n_out < 1024) begin
      outs[n_out] = int'(out_data);
      n_out = n_out + 1;
    end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic reset_dut(input logic [19:0] r);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; ratio = r;
    repeat (3) @(negedge clk);
    n_out = 0;
    rst = 1'b0;
  endtask

  task automatic send(input int v);
    in_valid = 1'b1;
    in_data  = 16'(v);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic real lagr(input int xm, input int x0, input int x1,
                               input int x2, input real m);
    return xm * (-m * (m - 1.0) * (m - 2.0) / 6.0)
         + x0 * ((m + 1.0) * (m - 1.0) * (m - 2.0) / 2.0)
         + x1 * (-(m + 1.0) * m * (m - 2.0) / 2.0)
         + x2 * ((m + 1.0) * m * (m - 1.0) / 6.0);
  endfunction

  // full run: stream n samples, then compare count and every value
  task automatic run_case(input string tag, input logic [19:0] r, input int n,
                          input int tol, input bit gaps);
    int exp_cnt;
    reset_dut(r);
    for (int i = 0; i < n; i++) begin
      send(stim[i]);
      if (gaps) repeat (i % 3) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    exp_cnt = 0;
    while (1 + int'((longint'(exp_cnt) * r) >>> 16) + 2 <= n - 1) exp_cnt++;
    chk(n_out == exp_cnt, {tag, " count R3"}, n_out, exp_cnt);
    for (int k = 0; k < exp_cnt && k < n_out; k++) begin
      longint pos = longint'(k) * r;
      int idx = 1 + int'(pos >>> 16);
      real m = real'(pos & 64'hFFFF) / 65536.0;
      real y = lagr(stim[idx-1], stim[idx], stim[idx+1], stim[idx+2], m);
      int e = int'(y);
      int d;
      if (e > 32767) e = 32767;
      if (e < -32768) e = -32768;
      d = outs[k] - e;
      chk(d <= tol && d >= -tol, tag, outs[k], e);
    end
  endtask

  task automatic test_reset;
    reset_dut(20'h10000);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic test_prime;
    reset_dut(20'h10000);
    for (int i = 0; i < 3; i++) send(100 * (i + 1));
    repeat (12) @(negedge clk);
    chk(n_out == 0, "R2 no output before fourth", n_out, 0);
    chk(in_ready == 1'b1, "R2 still ready", int'(in_ready), 1);
    send(400);
    repeat (12) @(negedge clk);
    chk(n_out == 1, "R2 one output after fourth", n_out, 1);
    chk(outs[0] == 200, "R2 first output is second sample", outs[0], 200);
  endtask

  task automatic test_unity;
    for (int i = 0; i < 32; i++) stim[i] = (i * 7919) % 60001 - 30000;
    run_case("R7 unity exact", 20'h10000, 32, 0, 1'b0);
  endtask

  task automatic test_upsample;
    for (int i = 0; i < 40; i++) stim[i] = int'(12000.0 * $sin(0.37 * i));
    run_case("R6 ratio 0.3", 20'h04CCD, 40, 1, 1'b0);
  endtask

  task automatic test_downsample;
    for (int i = 0; i < 90; i++) stim[i] = (i * 2971) % 50000 - 25000;
    run_case("R4 R6 ratio 2.75", 20'h2C000, 90, 1, 1'b0);
  endtask

  task automatic test_const;
    for (int i = 0; i < 30; i++) stim[i] = -777;
    run_case("R9 constant", 20'h0C51F, 30, 0, 1'b0);
  endtask

  task automatic test_sat;
    for (int i = 0; i < 24; i++)
      stim[i] = ((i % 4) == 1 || (i % 4) == 2) ? ((i % 8) < 4 ? 32767 : -32768)
                                               : ((i % 8) < 4 ? -32768 : 32767);
    run_case("R8 saturate", 20'h08000, 24, 1, 1'b0);
  endtask

  task automatic test_stall;
    for (int i = 0; i < 40; i++) stim[i] = (i * i * 37) % 40000 - 20000;
    run_case("R5 gapped input", 20'h18000, 40, 1, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_prime();
    test_unity();
    test_upsample();
    test_downsample();
    test_const();
    test_sat();
    test_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule